// File: doc/BRIEF.md
# Oversampling Phase Debounce Filter

This block cleans up the two phase lines of a quadrature encoder before they reach a decoder. Each line has its own filter lane, and every lane has the same logic. The lanes run off a one-cycle microsecond tick and share a programmable period measured in ticks. When filtering is on, each lane samples its raw input on every tick of the period. At the end of the period the lane accepts a new level only if every sample in that period matched. If any sample differed, the lane keeps its previous level. Accepted levels appear together with a one-cycle period-end strobe, so the decoder sees one update per period. The reported phases therefore lag the pins by one period.

When filtering is off, the lanes do not oversample. Each lane copies the raw level it sees on the last tick of each period. On reset, and on the cycle filtering is switched on, each lane loads the raw level directly. The lane then ignores the rest of the current period and starts voting at the next period. A level that stays steady for more than two periods is guaranteed to reach the output.

Top module: `qphase_debounce`

## Requirements
- R1: While reset is held, every filtered phase output follows its raw input from one clock edge to the next, and the period-end strobe is low.
- R2: The period length is the programmed tick count clamped to the range MIN_TICKS..MAX_TICKS. The strobe goes high for exactly one cycle, on the clock after the tick that completes a period. With a tick every G cycles, consecutive strobes are therefore length×G cycles apart.
- R3: With filtering on and the lane armed, the last tick of a period loads the output with the sampled level if all samples of that period were equal. Otherwise the output keeps its previous level.
- R4: Apart from reset and the switch-on cycle, a filtered output can change only on the cycle that the period-end strobe is high.
- R5: With filtering off, each output takes the raw level sampled on the last tick of every period. No other sample has any effect.
- R6: On the clock after filtering is switched on, each output equals the raw level sampled at that edge. The period in progress at that moment never updates the output; voting starts with the next full period.
- R7: Phase bit 0 and phase bit 1 are filtered independently, so a disturbance on one channel never changes the other channel's output.
- R8: With filtering on, a raw level held steady for more than two full periods is present at the output when that interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_en_i | input | 1 | 1 = unanimity filtering, 0 = single sample per period |
| tick_1us_i | input | 1 | One-cycle sampling enable, nominally every microsecond |
| period_ticks_i | input | LEN_W | Period length in ticks; values outside MIN_TICKS..MAX_TICKS are clamped |
| phase_raw_i | input | NCH | Synchronised raw phase levels; bit 0 is channel A, bit 1 is channel B |
| phase_o | output | NCH | Filtered phase levels |
| period_end_o | output | 1 | One-cycle strobe marking each period boundary |

## Verification
The hardest cases to reach are the ones where switching filtering on coincides with a period boundary, or falls in the middle of a period. In the mid-period case, the discarded partial period must not update the output, even though its samples are uniform. The bench keeps its own tick counter in the reference model. It uses that counter to time the switch-on to a chosen tick, and it drives a clean level straight afterwards. It can then show that the first boundary holds the value loaded at switch-on and that only the second boundary takes the new level. Random phases with glitches, including glitches on channel A alone and random toggling of the enable, are compared against the model on every clock.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

   // Running vote of one lane over the current period
   typedef struct packed {
      logic have;   // at least one sample taken this period
      logic first;  // level of the first sample
      logic agree;  // every later sample matched the first
   } vote_st_t;

   localparam vote_st_t VOTE_IDLE = '{have: 1'b0, first: 1'b0, agree: 1'b0};

endpackage

// File: rtl/qpd_period_timer.sv
module qpd_period_timer #(
   parameter int MIN_TICKS = 128,
   parameter int MAX_TICKS = 16384,
   parameter int LEN_W     = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             last_o,
   output logic             bnd_o
);
   localparam int CNT_W = $clog2(MAX_TICKS);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_TICKS);
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_c;
   logic             bnd_q;

   always_comb begin
      if (len_i < MIN_L)      len_c = MIN_L;
      else if (len_i > MAX_L) len_c = MAX_L;
      else                    len_c = len_i;
   end

   // >= keeps the period finite when the length is lowered mid-period
   assign last_o = tick_i && (LEN_W'(cnt_q) >= (len_c - LEN_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         bnd_q <= 1'b0;
      end else begin
         bnd_q <= last_o;
         if (tick_i) begin
            cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
         end
      end
   end

   assign bnd_o = bnd_q;
endmodule

// File: rtl/qpd_vote_lane.sv
module qpd_vote_lane
   import qpd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic en_i,
   input  logic rise_i,
   input  logic tick_i,
   input  logic last_i,
   output logic lvl_o
);
   vote_st_t st_q, st_nxt;
   logic     armed_q;
   logic     lvl_q;
   logic     vote_lvl, vote_ok;

   // Vote including the sample taken on the current tick
   always_comb begin
      st_nxt.have  = 1'b1;
      st_nxt.first = st_q.have ? st_q.first : raw_i;
      st_nxt.agree = st_q.have ? (st_q.agree && (raw_i == st_q.first)) : 1'b1;
      vote_lvl     = st_nxt.first;
      vote_ok      = st_nxt.agree;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q   <= raw_i;
         st_q    <= VOTE_IDLE;
         armed_q <= 1'b0;
      end else if (rise_i) begin
         lvl_q   <= raw_i;
         st_q    <= VOTE_IDLE;
         armed_q <= last_i;           // voting starts with the next full period
      end else if (!en_i) begin
         st_q    <= VOTE_IDLE;
         armed_q <= 1'b0;
         if (last_i) lvl_q <= raw_i;  // plain sample at the boundary
      end else if (tick_i) begin
         if (last_i) begin
            if (armed_q && vote_ok) lvl_q <= vote_lvl;
            st_q    <= VOTE_IDLE;
            armed_q <= 1'b1;
         end else begin
            st_q <= st_nxt;
         end
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/qphase_debounce.sv
module qphase_debounce #(
   parameter int NCH       = 2,
   parameter int MIN_TICKS = 128,
   parameter int MAX_TICKS = 16384,
   parameter int LEN_W     = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             filt_en_i,
   input  logic             tick_1us_i,
   input  logic [LEN_W-1:0] period_ticks_i,
   input  logic [NCH-1:0]   phase_raw_i,
   output logic [NCH-1:0]   phase_o,
   output logic             period_end_o
);
   generate
      if (MIN_TICKS < 2) begin : g_bad_min
         $error("MIN_TICKS must be at least 2");
      end
      if (MAX_TICKS < MIN_TICKS) begin : g_bad_max
         $error("MAX_TICKS must not be below MIN_TICKS");
      end
      if ((2 ** LEN_W) <= MAX_TICKS) begin : g_bad_w
         $error("LEN_W too narrow for MAX_TICKS");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
   endgenerate

   logic en_q;
   logic rise;
   logic last;

   always_ff @(posedge clk) begin
      en_q <= filt_en_i;   // in reset too: no switch-on event out of reset
   end

   assign rise = filt_en_i && !en_q && rst_n;

   qpd_period_timer #(
      .MIN_TICKS (MIN_TICKS),
      .MAX_TICKS (MAX_TICKS),
      .LEN_W     (LEN_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_1us_i),
      .len_i  (period_ticks_i),
      .last_o (last),
      .bnd_o  (period_end_o)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_lane
         qpd_vote_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (phase_raw_i[c]),
            .en_i   (filt_en_i),
            .rise_i (rise),
            .tick_i (tick_1us_i),
            .last_i (last),
            .lvl_o  (phase_o[c])
         );
      end
   endgenerate
endmodule

// File: rtl/qpd_check.sv
module qpd_check #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           filt_en_i,
   input logic           tick_1us_i,
   input logic [NCH-1:0] phase_raw_i,
   input logic [NCH-1:0] phase_o,
   input logic           period_end_o
);
   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      period_end_o |-> $past(tick_1us_i)); // R2

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      period_end_o |=> !period_end_o); // R2

   AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !period_end_o && !($past(filt_en_i) && !$past(filt_en_i, 2)))
      |-> $stable(phase_o)); // R4

   AST_PASS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end_o && !$past(filt_en_i)) |-> (phase_o == $past(phase_raw_i))); // R5

   AST_SWITCH_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(filt_en_i) && !$past(filt_en_i, 2))
      |-> (phase_o == $past(phase_raw_i))); // R6

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         AST_VOTE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (period_end_o && $past(filt_en_i) && (phase_o[c] != $past(phase_o[c])))
            |-> (phase_o[c] == $past(phase_raw_i[c]))); // R3
      end
   endgenerate
endmodule

bind qphase_debounce qpd_check #(.NCH(NCH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .filt_en_i    (filt_en_i),
   .tick_1us_i   (tick_1us_i),
   .phase_raw_i  (phase_raw_i),
   .phase_o      (phase_o),
   .period_end_o (period_end_o)
);

// File: tb/sim_qphase_debounce.sv
`timescale 1ns/1ps
module sim_qphase_debounce;
   localparam int MINT = 2;
   localparam int MAXT = 40;
   localparam int LW   = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          tick = 1'b0;
   logic [LW-1:0] plen = LW'(4);
   logic [1:0]    raw = 2'b10;
   logic [1:0]    ph;
   logic          bnd;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string tag = "R1";
   int gap = 2;
   int tdiv = 0;

   always #2.5 clk = ~clk;

   qphase_debounce #(.NCH(2), .MIN_TICKS(MINT), .MAX_TICKS(MAXT), .LEN_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .filt_en_i(en), .tick_1us_i(tick),
      .period_ticks_i(plen), .phase_raw_i(raw), .phase_o(ph), .period_end_o(bnd));

   function automatic int clampl(int v);
      return (v < MINT) ? MINT : ((v > MAXT) ? MAXT : v);
   endfunction

   // ---------------- reference model ----------------
   logic [1:0] m_ph;
   bit   m_bnd = 0, m_armed = 0, m_en_prev = 0, m_started = 0;
   int   m_cnt = 0;
   bit   mq0[$], mq1[$];

   function automatic bit uniform(bit q[$]);
      foreach (q[i]) if (q[i] != q[0]) return 0;
      return 1;
   endfunction

   always @(posedge clk) begin
      int  lenc;
      bit  last, rise;
      lenc = clampl(int'(plen));
      m_started = 1;
      if (!rst_n) begin
         m_ph = raw; m_cnt = 0; m_armed = 0; m_bnd = 0;
         mq0.delete(); mq1.delete(); m_en_prev = en;
      end else begin
         last  = tick && (m_cnt >= lenc - 1);
         rise  = en && !m_en_prev;
         m_bnd = last;
         if (rise) begin
            m_ph = raw; mq0.delete(); mq1.delete(); m_armed = last;
         end else if (!en) begin
            mq0.delete(); mq1.delete(); m_armed = 0;
            if (last) m_ph = raw;
         end else if (tick) begin
            mq0.push_back(raw[0]); mq1.push_back(raw[1]);
            if (last) begin
               if (m_armed) begin
                  if (uniform(mq0)) m_ph[0] = mq0[0];
                  if (uniform(mq1)) m_ph[1] = mq1[0];
               end
               mq0.delete(); mq1.delete(); m_armed = 1;
            end
         end
         if (tick) m_cnt = last ? 0 : m_cnt + 1;
         m_en_prev = en;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (m_started && !done) begin
         total++;
         if (ph !== m_ph) begin
            bad++;
            $display("FAIL %s phase_o act=%b exp=%b t=%0t", tag, ph, m_ph, $time);
         end
         total++;
         if (bnd !== m_bnd) begin
            bad++;
            $display("FAIL R2 period_end_o act=%b exp=%b t=%0t", bnd, m_bnd, $time);
         end
      end
   end

   // tick generator
   always @(negedge clk) begin
      #1;
      if (tdiv >= gap - 1) begin tick = 1'b1; tdiv = 0; end
      else begin tick = 1'b0; tdiv++; end
   end

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic run_rand(int n, int flip_pct, int gl_pct, bit only_a, bit en_rand);
      logic [1:0] lv = raw;
      for (int i = 0; i < n; i++) begin
         logic [1:0] gm;
         step();
         if ($urandom_range(99) < flip_pct) lv = 2'($urandom_range(3));
         gm[0] = ($urandom_range(99) < gl_pct);
         gm[1] = only_a ? 1'b0 : ($urandom_range(99) < gl_pct);
         raw = lv ^ gm;
         if (en_rand && $urandom_range(99) < 3) en = ~en;
      end
   endtask

   task automatic wait_ticks(int n);
      int k = 0;
      while (k < n) begin
         step();
         if (tick) k++;
      end
   endtask

   task automatic wait_bnd();
      do @(negedge clk); while (bnd !== 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         done = 1;
         $finish;
      end
   end

   initial begin
      int lenc, c0, c1;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "phase_o in reset", 32'(ph), 32'(2'b10));
      check("R1", "strobe in reset", 32'(bnd), 0);
      #2; raw = 2'b01;
      @(negedge clk);
      check("R1", "phase_o follows raw in reset", 32'(ph), 32'(2'b01));
      #2; rst_n = 1'b1;

      // R5: pass-through mode
      tag = "R5"; plen = LW'(4);
      run_rand(300, 30, 10, 0, 0);

      // R3: filtering with glitches
      tag = "R3"; en = 1'b1; plen = LW'(5);
      run_rand(1200, 4, 8, 0, 0);

      // R2: clamping and strobe spacing
      tag = "R2"; gap = 1; plen = LW'(0);
      run_rand(100, 5, 5, 0, 0);
      wait_bnd(); c0 = 0;
      do begin @(negedge clk); c0++; end while (bnd !== 1'b1);
      check("R2", "spacing len 0 gap 1", 32'(c0), 32'(MINT));
      plen = LW'(63);
      run_rand(200, 5, 5, 0, 0);
      wait_bnd(); c1 = 0;
      do begin @(negedge clk); c1++; end while (bnd !== 1'b1);
      check("R2", "spacing len 63 gap 1", 32'(c1), 32'(MAXT));
      gap = 2; plen = LW'(6);
      wait_bnd(); wait_bnd(); c1 = 0;
      do begin @(negedge clk); c1++; end while (bnd !== 1'b1);
      check("R2", "spacing len 6 gap 2", 32'(c1), 32'(12));

      // R6: switch-on mid period, partial period must not update
      tag = "R6"; plen = LW'(4); lenc = 4;
      en = 1'b0; raw = 2'b11;
      wait_ticks(3 * lenc);
      do step(); while (!(tick && m_cnt == 0));
      en = 1'b1; raw = 2'b10;
      step(); raw = 2'b01;
      check("R6", "load at switch-on", 32'(ph), 32'(2'b10));
      wait_bnd();
      check("R6", "partial period holds", 32'(ph), 32'(2'b10));
      wait_bnd();
      check("R3", "first full period accepted", 32'(ph), 32'(2'b01));

      // R6: switch-on on the last tick of a period
      step(); en = 1'b0;
      wait_ticks(2 * lenc);
      do step(); while (!(tick && m_cnt == lenc - 1));
      en = 1'b1; raw = 2'b00;
      step(); raw = 2'b11;
      check("R6", "load at switch-on on boundary", 32'(ph), 32'(2'b00));
      wait_bnd();
      check("R6", "next full period accepted", 32'(ph), 32'(2'b11));

      // R8: steady level beyond two periods reaches output
      tag = "R8"; raw = 2'b00;
      wait_ticks(3 * lenc);
      check("R8", "settled low", 32'(ph), 0);
      raw = 2'b11;
      wait_ticks(2 * lenc + 2);
      @(negedge clk);
      check("R8", "steady level passed", 32'(ph), 32'(2'b11));

      // R7: channel A never agrees, channel B moves cleanly
      tag = "R7"; raw = 2'b00;
      wait_ticks(3 * lenc);
      raw = 2'b10;
      for (int i = 0; i < 4 * lenc; i++) begin
         step();
         if (tick) raw[0] = ~raw[0];
      end
      @(negedge clk);
      check("R7", "channel B took new level", 32'(ph[1]), 1);
      check("R7", "channel A held", 32'(ph[0]), 0);
      run_rand(600, 5, 15, 1, 0);

      // R4: random enable toggling
      tag = "R4"; plen = LW'(3);
      run_rand(1500, 5, 10, 0, 1);

      repeat (4) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule